// File: doc/BRIEF.md
# Mini UART Peripheral

A compact asynchronous serial port with one start bit, seven or eight data bits sent least significant bit first, one stop bit and no parity. Software drives it through a word-indexed register bus. Bytes written to the data register go into an eight-entry transmit FIFO and are shifted out on `tx_line`. Frames that arrive on `rx_line` are assembled into an eight-entry receive FIFO, and reading the data register takes one byte from that FIFO. The bit rate comes from a 16-bit divider: one bit lasts 8*(divider+1) clock cycles, and the receiver works on the resulting 8x oversampling ticks.

A level interrupt reports that received data is waiting or that the transmit FIFO has room. Each cause has its own enable bit and a companion arming bit, and both must be set for the cause to reach `irq`. An identify register gives the pending reason, with receive taking priority, and writing that register flushes either FIFO. The line-status and extended-status registers expose FIFO levels, idle flags, a sticky receive-overrun flag and the RTS and CTS levels.

The register bus takes one access per cycle and has no back-pressure. A write lands on the clock edge. Read data is combinational from the current state, and its side effects (popping the receive FIFO, clearing the overrun flag) take effect on the edge that ends the read cycle. Serial data does not wait for software: a frame that arrives while the receive FIFO is full is lost.

Register word indices: 0 data, 1 interrupt enable, 2 interrupt identify, 3 line control, 4 modem control, 5 line status, 6 scratch, 7 control, 8 extended status, 9 divider.

Top module: `mini_uart_periph`

## Requirements
- R1: One serial bit lasts 8*(D+1) clock cycles, where D is the 16-bit value in the divider register (index 9). D resets to 0.
- R2: Writing the data register (index 0) queues `bus_wdata[7:0]` for transmission. Each frame is a low start bit, the data bits least significant first, then a high stop bit. The line idles high.
- R3: Frames carry 8 data bits only when line control (index 3) bits 1:0 both read 1. Any other value gives 7 data bits: the transmitter drops bit 7 and the receiver stores bit 7 as 0.
- R4: A received frame with a high stop bit is pushed into the receive FIFO. Reading the data register returns the oldest byte in bits 7:0 and removes it.
- R5: Control (index 7) bit 0 enables the receiver and bit 1 enables the transmitter. Both reset to 1. A disabled receiver ignores the line, and a disabled transmitter keeps its FIFO contents and does not drive a frame.
- R6: `irq` is high when (enable bits 0 and 2 are set and the receive FIFO is non-empty) or (enable bits 1 and 3 are set and the transmit FIFO is not full). The interrupt enable register is index 1.
- R7: The identify register (index 2) reads 3'b001 when no enabled cause is pending. It reads 3'b100 for receive data, which wins when both causes are pending, and 3'b010 for transmit space.
- R8: Writing the identify register with bit 1 set empties the receive FIFO. Writing it with bit 2 set empties the transmit FIFO.
- R9: Line status (index 5) has bit 0 = receive FIFO non-empty, bit 5 = transmit FIFO not full, and bit 6 = transmit FIFO empty and transmitter idle.
- R10: Extended status (index 8) has: bit 0 receive data available, bit 1 transmit space, bit 2 receiver idle, bit 3 transmitter idle, bit 4 overrun, bit 5 transmit full, bit 6 RTS asserted, bit 7 CTS input level, bit 8 transmit FIFO empty, bit 9 transmit done, bits 19:16 receive fill level, bits 27:24 transmit fill level.
- R11: Each FIFO holds 8 bytes. A frame that arrives while the receive FIFO is full is dropped and sets the overrun flag, which stays set until extended status is read.
- R12: Modem control (index 4) bit 1 = 1 drives `rts_line` low, and 0 drives it high. The scratch register (index 6) reads back the last 32-bit value written to it.
- R13: After reset: `tx_line` high, `irq` low, `rts_line` high, identify = 1, line status = 0x60, extended status = 0x30E (with CTS low), control = 3, line control = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (enables read side effects) |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rx_line | input | 1 | Serial receive input |
| cts_line | input | 1 | Clear-to-send input, reported in status only |
| tx_line | output | 1 | Serial transmit output |
| rts_line | output | 1 | Request-to-send output, active low |
| irq | output | 1 | Level interrupt |

## Verification
The bench fills the receive FIFO with nine frames and checks that the ninth is lost, that overrun is set and then cleared by exactly one status read, and that the first eight bytes come back in order. A design that overwrote the oldest entry, or that let overrun clear by itself, would fail these checks. Enable pairs that lack their arming bit must leave `irq` low, and with both causes pending the identify register must report receive. A design that decoded only the low enable bits, or that got the priority backwards, would raise a spurious interrupt or report the wrong reason. The bench also covers a change of divider, 7-bit frames in both directions, and a disabled transmitter that must keep its FIFO while the line stays quiet. A wrong bit-time formula, a transmitter that ignored the enable, or a wrong 7-bit rule would show up as garbled frames or stray frames at the scoreboard.

// File: rtl/mini_uart_pkg.sv
`timescale 1ns/1ps
package mini_uart_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_DATA    = 4'd0;
  localparam logic [ADDR_W-1:0] A_IEN     = 4'd1;
  localparam logic [ADDR_W-1:0] A_IID     = 4'd2;
  localparam logic [ADDR_W-1:0] A_LINE    = 4'd3;
  localparam logic [ADDR_W-1:0] A_MODEM   = 4'd4;
  localparam logic [ADDR_W-1:0] A_LSTAT   = 4'd5;
  localparam logic [ADDR_W-1:0] A_SCRATCH = 4'd6;
  localparam logic [ADDR_W-1:0] A_CTRL    = 4'd7;
  localparam logic [ADDR_W-1:0] A_XSTAT   = 4'd8;
  localparam logic [ADDR_W-1:0] A_BAUD    = 4'd9;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/mini_uart_fifo.sv
`timescale 1ns/1ps
module mini_uart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic wr_ok, rd_ok;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;
  assign dout  = mem_q[rp_q];
  assign count = cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= nxt(wp_q);
      if (rd_ok) rp_q <= nxt(rp_q);
      if (wr_ok && !rd_ok) cnt_q <= cnt_q + 1'b1;
      else if (rd_ok && !wr_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wp_q] <= din;
  end

  assert_fill_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/mini_uart_tx.sv
`timescale 1ns/1ps
module mini_uart_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 8,
  localparam int TW = $clog2(OVS),
  localparam int BW = $clog2(DATA_W + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              eight_bit,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic              txd,
  output logic              busy
);
  logic [DATA_W+1:0] sh_q;
  logic [BW-1:0] bits_q;
  logic [TW-1:0] tcnt_q;
  logic busy_q;

  assign fifo_pop = !busy_q && en && tick && !fifo_empty;
  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '1;
      bits_q <= '0;
      tcnt_q <= '0;
      busy_q <= 1'b0;
    end else if (fifo_pop) begin
      busy_q <= 1'b1;
      tcnt_q <= '0;
      if (eight_bit) begin
        sh_q   <= {1'b1, fifo_data, 1'b0};
        bits_q <= BW'(DATA_W + 2);
      end else begin
        sh_q   <= {2'b11, fifo_data[DATA_W-2:0], 1'b0};
        bits_q <= BW'(DATA_W + 1);
      end
    end else if (busy_q && en && tick) begin
      if (tcnt_q == TW'(OVS - 1)) begin
        tcnt_q <= '0;
        sh_q   <= {1'b1, sh_q[DATA_W+1:1]};
        bits_q <= bits_q - 1'b1;
        if (bits_q == BW'(1)) busy_q <= 1'b0;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assert_frozen_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (en || $stable(txd)));
endmodule

// File: rtl/mini_uart_rx.sv
`timescale 1ns/1ps
module mini_uart_rx
  import mini_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 8,
  localparam int TW = $clog2(OVS),
  localparam int IW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              eight_bit,
  input  logic              rxd,
  output logic              push,
  output logic [DATA_W-1:0] data,
  output logic              idle
);
  rx_state_e st_q;
  logic [TW-1:0] tcnt_q;
  logic [IW-1:0] idx_q;
  logic [DATA_W-1:0] sh_q;
  logic [1:0] sync_q;
  logic rxd_s, last_bit;

  assign rxd_s    = sync_q[1];
  assign last_bit = eight_bit ? (idx_q == IW'(DATA_W - 1)) : (idx_q == IW'(DATA_W - 2));
  assign push = en && tick && (st_q == RX_STOP) && (tcnt_q == TW'(OVS - 1)) && rxd_s;
  assign data = sh_q;
  assign idle = (st_q == RX_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      tcnt_q <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else if (!en) begin
      st_q <= RX_IDLE;
    end else if (tick) begin
      case (st_q)
        RX_IDLE: if (!rxd_s) begin
          st_q   <= RX_START;
          tcnt_q <= '0;
        end
        RX_START: if (tcnt_q == TW'(OVS / 2 - 2)) begin
          tcnt_q <= '0;
          if (!rxd_s) begin
            st_q  <= RX_DATA;
            idx_q <= '0;
            sh_q  <= '0;
          end else begin
            st_q <= RX_IDLE;
          end
        end else tcnt_q <= tcnt_q + 1'b1;
        RX_DATA: if (tcnt_q == TW'(OVS - 1)) begin
          tcnt_q     <= '0;
          sh_q[idx_q] <= rxd_s;
          if (last_bit) st_q <= RX_STOP;
          else          idx_q <= idx_q + 1'b1;
        end else tcnt_q <= tcnt_q + 1'b1;
        default: if (tcnt_q == TW'(OVS - 1)) begin
          tcnt_q <= '0;
          st_q   <= RX_IDLE;
        end else tcnt_q <= tcnt_q + 1'b1;
      endcase
    end
  end

  assert_off_means_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> idle);
endmodule

// File: rtl/mini_uart_periph.sv
`timescale 1ns/1ps
module mini_uart_periph
  import mini_uart_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int OVS        = 8,
  parameter int DIV_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_line,
  input  logic        cts_line,
  output logic        tx_line,
  output logic        rts_line,
  output logic        irq
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [3:0]       ien_q;
  logic [1:0]       lcr_q;
  logic             rts_on_q;
  logic [31:0]      scratch_q;
  logic [1:0]       ctl_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] bcnt_q;
  logic             ovr_q;
  logic             tick, eight_bit;

  logic             tx_push, tx_pop, tx_full, tx_empty, tx_busy, tx_clr;
  logic [DATA_W-1:0] tx_dout;
  logic [CW-1:0]    tx_cnt;
  logic             rx_push, rx_pop, rx_full, rx_empty, rx_idle, rx_clr;
  logic [DATA_W-1:0] rx_din, rx_dout;
  logic [CW-1:0]    rx_cnt;
  logic             rx_int, tx_int, xstat_rd;
  logic [2:0]       iid;
  logic [31:0]      xstat, lstat;

  assign eight_bit = (lcr_q == 2'b11);
  assign tick      = (bcnt_q >= div_q);
  assign tx_push   = bus_wr && (bus_addr == A_DATA);
  assign rx_pop    = bus_rd && (bus_addr == A_DATA);
  assign xstat_rd  = bus_rd && (bus_addr == A_XSTAT);
  assign tx_clr    = bus_wr && (bus_addr == A_IID) && bus_wdata[2];
  assign rx_clr    = bus_wr && (bus_addr == A_IID) && bus_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) bcnt_q <= '0;
    else        bcnt_q <= tick ? '0 : bcnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q     <= '0;
      lcr_q     <= '0;
      rts_on_q  <= 1'b0;
      scratch_q <= '0;
      ctl_q     <= 2'b11;
      div_q     <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_IEN:     ien_q     <= bus_wdata[3:0];
        A_LINE:    lcr_q     <= bus_wdata[1:0];
        A_MODEM:   rts_on_q  <= bus_wdata[1];
        A_SCRATCH: scratch_q <= bus_wdata;
        A_CTRL:    ctl_q     <= bus_wdata[1:0];
        A_BAUD:    div_q     <= bus_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  ovr_q <= 1'b0;
    else if (rx_push && rx_full) ovr_q <= 1'b1;
    else if (xstat_rd)           ovr_q <= 1'b0;
  end

  mini_uart_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push),
    .din(bus_wdata[DATA_W-1:0]), .pop(tx_pop), .dout(tx_dout),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  mini_uart_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push),
    .din(rx_din), .pop(rx_pop), .dout(rx_dout),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  mini_uart_tx #(.DATA_W(DATA_W), .OVS(OVS)) tx_i (
    .clk(clk), .rst_n(rst_n), .en(ctl_q[1]), .tick(tick), .eight_bit(eight_bit),
    .fifo_empty(tx_empty), .fifo_data(tx_dout), .fifo_pop(tx_pop),
    .txd(tx_line), .busy(tx_busy));

  mini_uart_rx #(.DATA_W(DATA_W), .OVS(OVS)) rx_i (
    .clk(clk), .rst_n(rst_n), .en(ctl_q[0]), .tick(tick), .eight_bit(eight_bit),
    .rxd(rx_line), .push(rx_push), .data(rx_din), .idle(rx_idle));

  assign rx_int = ien_q[0] && ien_q[2] && !rx_empty;
  assign tx_int = ien_q[1] && ien_q[3] && !tx_full;
  assign irq    = rx_int || tx_int;
  assign iid    = rx_int ? 3'b100 : (tx_int ? 3'b010 : 3'b001);
  assign rts_line = !rts_on_q;

  always_comb begin
    lstat    = '0;
    lstat[0] = !rx_empty;
    lstat[5] = !tx_full;
    lstat[6] = tx_empty && !tx_busy;
    xstat    = '0;
    xstat[0] = !rx_empty;
    xstat[1] = !tx_full;
    xstat[2] = rx_idle;
    xstat[3] = !tx_busy;
    xstat[4] = ovr_q;
    xstat[5] = tx_full;
    xstat[6] = rts_on_q;
    xstat[7] = cts_line;
    xstat[8] = tx_empty;
    xstat[9] = tx_empty && !tx_busy;
    xstat[19:16] = 4'(rx_cnt);
    xstat[27:24] = 4'(tx_cnt);
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DATA:    bus_rdata = rx_empty ? '0 : 32'(rx_dout);
      A_IEN:     bus_rdata = 32'(ien_q);
      A_IID:     bus_rdata = 32'(iid);
      A_LINE:    bus_rdata = 32'(lcr_q);
      A_MODEM:   bus_rdata = {30'd0, rts_on_q, 1'b0};
      A_LSTAT:   bus_rdata = lstat;
      A_SCRATCH: bus_rdata = scratch_q;
      A_CTRL:    bus_rdata = 32'(ctl_q);
      A_XSTAT:   bus_rdata = xstat;
      A_BAUD:    bus_rdata = 32'(div_q);
      default:   bus_rdata = '0;
    endcase
  end

  assert_unarmed_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_q[2] && !ien_q[3]) |-> !irq);
  assert_overrun_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(rx_full));
endmodule

// File: tb/mini_uart_periph_tb_top.sv
`timescale 1ns/1ps
module mini_uart_periph_tb_top;
  import mini_uart_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rx_line = 1'b1, cts_line = 1'b0;
  logic tx_line, rts_line, irq;

  mini_uart_periph dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_line(rx_line), .cts_line(cts_line), .tx_line(tx_line),
    .rts_line(rts_line), .irq(irq));

  int total = 0, bad = 0;
  int bt = 16;
  int mon_nb = 8;
  bit mon_busy = 1'b0;
  bit ended = 1'b0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  logic [31:0] v;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // driver: queue expected transmit byte, then write it
  task automatic push_tx(input logic [7:0] d);
    tx_q.push_back(d);
    reg_wr(A_DATA, 32'(d));
  endtask

  task automatic wait_tx();
    do @(negedge clk); while (tx_q.size() != 0 || mon_busy);
  endtask

  task automatic send_rx(input logic [7:0] d, input int nb, input bit keep);
    if (keep) rx_q.push_back(d);
    @(negedge clk);
    rx_line = 1'b0;
    repeat (bt) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx_line = d[i];
      repeat (bt) @(negedge clk);
    end
    rx_line = 1'b1;
    repeat (2 * bt) @(negedge clk);
  endtask

  task automatic pop_rx(input string tag);
    logic [31:0] r;
    logic [7:0] e;
    reg_rd(A_DATA, r);
    e = (rx_q.size() != 0) ? rx_q.pop_front() : 8'h00;
    check(tag, r, 32'(e));
  endtask

  // monitor: decode frames on tx_line and compare with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx_line === 1'b0) begin
        logic [7:0] got;
        logic [7:0] exp;
        mon_busy = 1'b1;
        got = '0;
        repeat (bt / 2) @(negedge clk);
        check("R2 start bit", 32'(tx_line), 32'd0);
        for (int i = 0; i < mon_nb; i++) begin
          repeat (bt) @(negedge clk);
          got[i] = tx_line;
        end
        repeat (bt) @(negedge clk);
        check("R2 stop bit", 32'(tx_line), 32'd1);
        if (tx_q.size() == 0) begin
          check("R2/R5 unexpected frame", 32'(got), 32'hFFFF_FFFF);
        end else begin
          exp = tx_q.pop_front();
          if (mon_nb == 7) exp[7] = 1'b0;
          check("R1/R2/R3 tx byte", 32'(got), 32'(exp));
        end
        mon_busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog all actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13 tx_line", 32'(tx_line), 32'd1);
    check("R13 irq", 32'(irq), 32'd0);
    check("R13 rts_line", 32'(rts_line), 32'd1);
    reg_rd(A_IID, v);   check("R13 identify", v, 32'h1);
    reg_rd(A_LSTAT, v); check("R13 line status", v, 32'h60);
    reg_rd(A_XSTAT, v); check("R13 ext status", v, 32'h30E);
    reg_rd(A_CTRL, v);  check("R13 control", v, 32'h3);
    reg_rd(A_LINE, v);  check("R13 line control", v, 32'h0);
    reg_rd(A_BAUD, v);  check("R1 divider reset", v, 32'h0);

    reg_wr(A_BAUD, 32'd1);
    reg_wr(A_LINE, 32'd3);
    // R2 eight-bit transmit
    push_tx(8'hA5);
    push_tx(8'h3C);
    wait_tx();
    // R1 other divider
    bt = 32;
    reg_wr(A_BAUD, 32'd3);
    push_tx(8'h81);
    wait_tx();
    bt = 16;
    reg_wr(A_BAUD, 32'd1);

    // R3 seven-bit mode both ways (one low bit set is not enough)
    reg_wr(A_LINE, 32'd1);
    mon_nb = 7;
    push_tx(8'hD6);
    wait_tx();
    send_rx(8'h5A, 7, 1'b1);
    pop_rx("R3 rx seven-bit");
    reg_wr(A_LINE, 32'd3);
    mon_nb = 8;

    // R4 receive and pop
    send_rx(8'hC3, 8, 1'b1);
    send_rx(8'h7E, 8, 1'b1);
    reg_rd(A_LSTAT, v); check("R9 rx available", v & 32'h1, 32'h1);
    reg_rd(A_XSTAT, v); check("R10 rx fill", (v >> 16) & 32'hF, 32'd2);
    pop_rx("R4 first byte");
    pop_rx("R4 second byte");
    reg_rd(A_LSTAT, v); check("R4 rx drained", v & 32'h1, 32'h0);

    // R6/R7 interrupts
    reg_wr(A_IEN, 32'h5);
    #1 check("R6 rx armed, empty", 32'(irq), 32'd0);
    reg_rd(A_IID, v); check("R7 none pending", v, 32'h1);
    send_rx(8'h11, 8, 1'b1);
    check("R6 rx irq", 32'(irq), 32'd1);
    reg_rd(A_IID, v); check("R7 rx reason", v, 32'h4);
    reg_wr(A_IEN, 32'h1);
    #1 check("R6 rx not armed", 32'(irq), 32'd0);
    reg_wr(A_IEN, 32'hF);
    reg_rd(A_IID, v); check("R7 rx priority", v, 32'h4);
    pop_rx("R4 irq byte");
    reg_rd(A_IID, v); check("R7 tx reason", v, 32'h2);
    reg_wr(A_IEN, 32'hE);
    #1 check("R6 tx irq", 32'(irq), 32'd1);
    reg_wr(A_IEN, 32'h2);
    #1 check("R6 tx not armed", 32'(irq), 32'd0);
    reg_wr(A_IEN, 32'h0);

    // R5 receiver disabled
    reg_wr(A_CTRL, 32'h2);
    send_rx(8'h99, 8, 1'b0);
    reg_rd(A_LSTAT, v); check("R5 rx off ignores line", v & 32'h1, 32'h0);
    // R5 transmitter disabled keeps FIFO, line quiet
    reg_wr(A_CTRL, 32'h1);
    for (int i = 0; i < 8; i++) reg_wr(A_DATA, 32'h55 + i);
    begin
      int lows = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (tx_line !== 1'b1) lows++;
      end
      check("R5 tx off line quiet", 32'(lows), 32'd0);
    end
    reg_rd(A_XSTAT, v);
    check("R10 tx fill full", (v >> 24) & 32'hF, 32'd8);
    check("R11 tx full flags", v & 32'h10A, 32'h008);
    reg_rd(A_LSTAT, v); check("R9 no tx space", v & 32'h60, 32'h0);
    // R8 flush transmit
    reg_wr(A_IID, 32'h4);
    reg_rd(A_XSTAT, v);
    check("R8 tx flushed", v & 32'h0F00_0300, 32'h0000_0300);
    reg_wr(A_CTRL, 32'h3);

    // R8 flush receive
    send_rx(8'h01, 8, 1'b0);
    send_rx(8'h02, 8, 1'b0);
    reg_rd(A_XSTAT, v); check("R10 rx fill before flush", (v >> 16) & 32'hF, 32'd2);
    reg_wr(A_IID, 32'h2);
    reg_rd(A_LSTAT, v); check("R8 rx flushed", v & 32'h1, 32'h0);

    // R11 overrun
    for (int i = 0; i < 9; i++) send_rx(8'h30 + 8'(i), 8, (i < 8));
    reg_rd(A_XSTAT, v);
    check("R11 fill eight", (v >> 16) & 32'hF, 32'd8);
    check("R11 overrun set", (v >> 4) & 32'h1, 32'd1);
    reg_rd(A_XSTAT, v);
    check("R11 overrun cleared", (v >> 4) & 32'h1, 32'd0);
    for (int i = 0; i < 8; i++) pop_rx("R11 kept order");
    reg_rd(A_LSTAT, v); check("R11 ninth dropped", v & 32'h1, 32'h0);

    // R12 RTS and scratch
    reg_wr(A_MODEM, 32'h2);
    #1 check("R12 rts low", 32'(rts_line), 32'd0);
    reg_rd(A_XSTAT, v); check("R10 rts bit", (v >> 6) & 32'h1, 32'd1);
    reg_wr(A_MODEM, 32'h0);
    #1 check("R12 rts high", 32'(rts_line), 32'd1);
    reg_wr(A_SCRATCH, 32'hDEAD_BEEF);
    reg_rd(A_SCRATCH, v); check("R12 scratch", v, 32'hDEAD_BEEF);
    cts_line = 1'b1;
    reg_rd(A_XSTAT, v); check("R10 cts bit", (v >> 7) & 32'h1, 32'd1);

    // final transmit after re-enable
    push_tx(8'h6B);
    wait_tx();
    repeat (20) @(negedge clk);
    summary();
  end
endmodule